// File: doc/BRIEF.md
# Odd-Multiple Constant Lookup Multiplier

This block multiplies an unsigned input word by a constant that is fixed when the design is built. It does not store every product. Its table keeps only the odd multiples of the constant, so the table is half the size a full product table would need. An even input is first split into an odd factor and a power of two. The odd factor selects a table word, and a barrel shifter then applies the power of two. An input of zero has no odd factor, so for that case a forced-zero path overrides the table.

The input word is captured on a clock edge only when its valid strobe is high. The product is formed from the captured word, so a result appears one cycle after its input was presented. The valid output repeats the input strobe one cycle later. While the strobe is low, the captured word and therefore the product hold their last values. The input width, the constant width and the constant value are parameters.

Top module: `oms_const_mult`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, out_valid is 0 and product is 0.
- R2: out_valid equals the value of in_valid at the preceding rising clock edge.
- R3: After an edge where in_valid is 1, product equals in_x multiplied by CONST_VAL, as an unsigned value IN_W+CONST_W bits wide. This holds for every odd in_x.
- R4: For every even, nonzero in_x, product equals in_x times CONST_VAL. This includes in_x = 2^(IN_W-1), which needs the largest shift, IN_W-1 places.
- R5: After an edge where in_valid is 1 and in_x is 0, product is exactly 0.
- R6: After an edge where in_valid is 0, product keeps its previous value, whatever in_x is.
- R7: product never exceeds (2^IN_W - 1) times CONST_VAL. At in_x = 2^IN_W - 1 this full value is returned without truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe; in_x is captured at an edge when this is 1 |
| in_x | input | IN_W | Unsigned multiplicand |
| out_valid | output | 1 | in_valid delayed by one cycle |
| product | output | IN_W+CONST_W | in_x times CONST_VAL for the last captured input |

## Verification
The assertions assume that in_valid is held low while reset is asserted. With that assumption, the first delayed strobe after reset release compares against a known 0. They also assume that in_x is stable around each rising edge. The stimulus meets both assumptions: reset is released at a falling edge with the strobe already low, and every input is changed one nanosecond after a rising edge. Some strobe-low cycles drive deliberately changing in_x values, so the hold behaviour is tested with inputs that would alter the product if they were captured.

// File: rtl/oms_pkg.sv
package oms_pkg;

  // Width of a shift-amount field able to encode 0 .. in_w-1.
  function automatic int shamt_width(int in_w);
    return (in_w <= 2) ? 1 : $clog2(in_w);
  endfunction

endpackage

// File: rtl/oms_encoder.sv
module oms_encoder #(
  parameter int IN_W  = 6,
  parameter int SH_W  = 3,
  parameter int ADR_W = IN_W - 1
) (
  input  logic [IN_W-1:0]  x,
  output logic [SH_W-1:0]  shamt,
  output logic [ADR_W-1:0] addr,
  output logic             is_zero
);

  logic [IN_W-1:0] odd_part;

  // Trailing-zero count: scan downward so the lowest set bit wins.
  always_comb begin
    shamt = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      if (x[i]) shamt = SH_W'(i);
    end
  end

  // Odd factor, then drop its always-one LSB to form the table index.
  always_comb begin
    odd_part = x >> shamt;
    addr     = ADR_W'(odd_part >> 1);
    is_zero  = (x == '0);
  end

endmodule

// File: rtl/oms_odd_table.sv
module oms_odd_table #(
  parameter int IN_W      = 6,
  parameter int CONST_W   = 8,
  parameter int CONST_VAL = 173,
  parameter int ADR_W     = IN_W - 1
) (
  input  logic [ADR_W-1:0]         addr,
  output logic [IN_W+CONST_W-1:0]  word
);

  localparam int PROD_W = IN_W + CONST_W;
  localparam int DEPTH  = 1 << ADR_W;

  logic [PROD_W-1:0] words [DEPTH];

  // Entry k holds (2k+1) * CONST_VAL, computed at elaboration.
  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    localparam logic [PROD_W-1:0] ODD_MUL =
      PROD_W'(2 * k + 1) * PROD_W'(CONST_VAL);
    assign words[k] = ODD_MUL;
  end

  assign word = words[addr];

endmodule

// File: rtl/oms_shifter.sv
module oms_shifter #(
  parameter int DATA_W = 14,
  parameter int SH_W   = 3
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  // Logarithmic shifter: stage s shifts by 2^s when its control bit is set.
  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    assign stg[s+1] = shamt[s] ? (stg[s] << (1 << s)) : stg[s];
  end

  assign dout = stg[SH_W];

endmodule

// File: rtl/oms_const_mult.sv
module oms_const_mult #(
  parameter int IN_W      = 6,
  parameter int CONST_W   = 8,
  parameter int CONST_VAL = 173
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [IN_W-1:0]          in_x,
  output logic                     out_valid,
  output logic [IN_W+CONST_W-1:0]  product
);

  localparam int PROD_W = IN_W + CONST_W;
  localparam int SH_W   = oms_pkg::shamt_width(IN_W);
  localparam int ADR_W  = IN_W - 1;

  logic [IN_W-1:0]   x_q, x_d;
  logic              v_q, v_d;
  logic [SH_W-1:0]   shamt;
  logic [ADR_W-1:0]  addr;
  logic              is_zero;
  logic [PROD_W-1:0] odd_word;
  logic [PROD_W-1:0] shifted;

  // Next-state: load the operand only on a strobe.
  always_comb begin
    x_d = in_valid ? in_x : x_q;
    v_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      v_q <= 1'b0;
    end else begin
      x_q <= x_d;
      v_q <= v_d;
    end
  end

  oms_encoder #(
    .IN_W (IN_W),
    .SH_W (SH_W),
    .ADR_W(ADR_W)
  ) u_enc (
    .x      (x_q),
    .shamt  (shamt),
    .addr   (addr),
    .is_zero(is_zero)
  );

  oms_odd_table #(
    .IN_W     (IN_W),
    .CONST_W  (CONST_W),
    .CONST_VAL(CONST_VAL),
    .ADR_W    (ADR_W)
  ) u_tab (
    .addr(addr),
    .word(odd_word)
  );

  oms_shifter #(
    .DATA_W(PROD_W),
    .SH_W  (SH_W)
  ) u_shf (
    .din  (odd_word),
    .shamt(shamt),
    .dout (shifted)
  );

  assign product   = is_zero ? '0 : shifted;
  assign out_valid = v_q;

endmodule

// File: rtl/oms_const_mult_chk.sv
module oms_const_mult_chk #(
  parameter int IN_W      = 6,
  parameter int CONST_W   = 8,
  parameter int CONST_VAL = 173
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [IN_W-1:0]          in_x,
  input logic                     out_valid,
  input logic [IN_W+CONST_W-1:0]  product
);

  localparam int PROD_W = IN_W + CONST_W;
  localparam logic [PROD_W-1:0] MAX_P =
    PROD_W'((1 << IN_W) - 1) * PROD_W'(CONST_VAL);

  // R2
  strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R3
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> product == (PROD_W'($past(in_x)) * PROD_W'(CONST_VAL)));

  // R5
  zero_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_x == '0) |=> product == '0);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

  // R7
  range_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    product <= MAX_P);

endmodule

bind oms_const_mult oms_const_mult_chk #(
  .IN_W     (IN_W),
  .CONST_W  (CONST_W),
  .CONST_VAL(CONST_VAL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_x     (in_x),
  .out_valid(out_valid),
  .product  (product)
);

// File: tb/oms_const_mult_test.sv
module oms_const_mult_test;

  localparam int IN_W      = 6;
  localparam int CONST_W   = 8;
  localparam int CONST_VAL = 173;
  localparam int PROD_W    = IN_W + CONST_W;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [IN_W-1:0]   in_x;
  logic              out_valid;
  logic [PROD_W-1:0] product;

  int    checks;
  int    errors;
  bit    done;
  string tag;

  // Behavioural reference state.
  bit                exp_v;
  logic [PROD_W-1:0] exp_p;

  oms_const_mult #(
    .IN_W     (IN_W),
    .CONST_W  (CONST_W),
    .CONST_VAL(CONST_VAL)
  ) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_x     (in_x),
    .out_valid(out_valid),
    .product  (product)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference model: updated at each rising edge from the stable inputs.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v = 1'b0;
      exp_p = '0;
    end else begin
      exp_v = in_valid;
      if (in_valid) begin
        longint full;
        full  = longint'(in_x) * longint'(CONST_VAL);
        exp_p = PROD_W'(full);
      end
    end
  end

  // Comparison away from the active edge, every cycle.
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== exp_v) begin
        errors++;
        $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, exp_v);
      end
      checks++;
      if (product !== exp_p) begin
        errors++;
        $display("FAIL %s product actual=%0d expected=%0d", tag, product, exp_p);
      end
    end
  end

  task automatic drive(input bit v, input int x);
    @(posedge clk);
    #1;
    in_valid = v;
    in_x     = IN_W'(x);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks   = 0;
    errors   = 0;
    done     = 1'b0;
    tag      = "R1";
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_x     = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle after release still idle and zero
    drive(1'b0, 0);

    // R3 / R4: every input back to back (odd and even values)
    tag = "R3";
    for (int x = 1; x < (1 << IN_W); x += 2) drive(1'b1, x);
    tag = "R4";
    for (int x = 2; x < (1 << IN_W); x += 2) drive(1'b1, x);
    // R4: powers of two, ending with the largest shift
    for (int s = 0; s < IN_W; s++) drive(1'b1, 1 << s);

    // R5: zero right after a large nonzero product
    tag = "R5";
    drive(1'b1, (1 << IN_W) - 1);
    drive(1'b1, 0);
    drive(1'b1, 40);
    drive(1'b1, 0);

    // R6: idle cycles with a changing operand
    tag = "R6";
    drive(1'b1, 37);
    for (int k = 0; k < 8; k++) drive(1'b0, k * 7 + 3);

    // R2: alternating strobe
    tag = "R2";
    for (int k = 0; k < 12; k++) drive(k[0], k * 5 + 1);

    // R7: top value without truncation
    tag = "R7";
    drive(1'b1, (1 << IN_W) - 1);
    drive(1'b0, 0);
    drive(1'b0, 0);
    @(posedge clk);
    #1;
    finish_run();
  end

endmodule